// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block is the interrupt core of a UART register interface. It watches the receive and transmit FIFO fill levels and a set of one-cycle event pulses from the serial logic. From these it builds a live status word that software can read, and it keeps a sticky interrupt status register. Software clears the sticky register by writing ones to it. A mask register is changed only through two write-only ports: one sets bits and one clears bits. The block drives one level interrupt from the bits that are both masked in and pending.

The FIFO storage, the shifters and the baud logic are outside this block. The FIFO levels and the trigger thresholds arrive as inputs. The register bus is word addressed. Writes take a write strobe. Reads are combinational and have no side effects. The word addresses are: 0 mask-set, 1 mask-clear, 2 mask readback, 3 sticky status, 4 live status. Every other address reads as zero.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, the mask and the sticky status both read zero and `irq` is low.
- R2: The live status word (address 4) has these bits. Bit 1 is high when the RX level is 0. Bit 2 is high when the RX level equals the FIFO depth. Bit 0 is high when the RX level is at least the RX threshold. Bit 3 is high when the TX level is 0. Bit 4 is high when the TX level equals the FIFO depth. Bit 13 is high when the TX level is at least the TX threshold. All other bits are zero.
- R3: Every clock cycle, live bits 4:0 are ORed into sticky bits 4:0, and live bit 13 is ORed into sticky bit 10.
- R4: An event pulse sets its sticky bit on the next clock edge. RX overrun sets bit 5, framing bit 6, parity bit 7, RX timeout bit 8, modem status bit 9 and TX overrun bit 12.
- R5: A write to address 3 clears every sticky bit written as one. Bits written as zero keep their value.
- R6: If a set source (a live flag or an event) and a write-one-to-clear hit the same sticky bit in the same cycle, the bit ends up set.
- R7: A write to address 0 ORs the written value into the mask. A write to address 1 clears the written bits from the mask. A write to address 2 leaves the mask unchanged.
- R8: `irq` is registered. On each clock edge it takes the value of the OR of (mask AND sticky) as it stood just before that edge. So `irq` follows a mask or status change one cycle late.
- R9: Only bits 0 to 10 and bit 12 exist in the mask and the sticky register, so every other bit reads zero. Writes to address 4 or to unmapped addresses change nothing, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rx_level | input | CW | Current RX FIFO fill level |
| rx_thresh | input | CW | RX trigger threshold |
| tx_level | input | CW | Current TX FIFO fill level |
| tx_thresh | input | CW | TX trigger threshold |
| ev_rx_overrun | input | 1 | RX overrun event pulse |
| ev_framing | input | 1 | Framing error event pulse |
| ev_parity | input | 1 | Parity error event pulse |
| ev_rx_timeout | input | 1 | RX timeout event pulse |
| ev_modem | input | 1 | Modem status change event pulse |
| ev_tx_overrun | input | 1 | TX overrun event pulse |
| irq | output | 1 | Level interrupt, registered |

## Verification
Some properties are checked by assertions on every cycle:
- Any set source must be present in the sticky register one cycle later.
- A written one with no competing set must leave its sticky bit cleared.
- The mask must follow its set and clear ports and must otherwise hold.
- Unimplemented bits must stay at zero.
- `irq` may rise or fall only after the masked overlap changed one cycle earlier.
- The RX empty and RX full flags must never both be high.

Other behaviour only the bench scenarios can show:
- The exact live flag values, from a sweep over every level and threshold pair.
- The fixed event-to-bit mapping.
- That writes to the mask readback, the live word and unmapped addresses are ignored.
- The precise one-cycle interrupt latency after a mask write.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int DW = 32;

  // sticky/mask bit positions (neighbouring software decodes these)
  localparam int B_RX_TRIG  = 0;
  localparam int B_RX_EMPTY = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_EMPTY = 3;
  localparam int B_TX_FULL  = 4;
  localparam int B_RX_OVR   = 5;
  localparam int B_FRAME    = 6;
  localparam int B_PARITY   = 7;
  localparam int B_RX_TMO   = 8;
  localparam int B_MODEM    = 9;
  localparam int B_TX_TRIG  = 10;
  localparam int B_TX_OVR   = 12;

  // TX trigger position in the live word differs from the sticky word
  localparam int L_TX_TRIG  = 13;

  localparam logic [DW-1:0] IMPL_BITS = 32'h0000_17FF;
  localparam logic [DW-1:0] LIVE_FOLD = 32'h0000_001F;

  localparam int A_MSET   = 0;
  localparam int A_MCLR   = 1;
  localparam int A_MASK   = 2;
  localparam int A_STICKY = 3;
  localparam int A_LIVE   = 4;

endpackage

// File: rtl/uirq_live.sv
module uirq_live
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [CW-1:0] rx_level_i,
  input  logic [CW-1:0] rx_thresh_i,
  input  logic [CW-1:0] tx_level_i,
  input  logic [CW-1:0] tx_thresh_i,
  output logic [DW-1:0] live_o
);

  localparam logic [CW-1:0] FULL_LVL = CW'(FIFO_DEPTH);

  always_comb begin
    live_o             = '0;
    live_o[B_RX_TRIG]  = (rx_level_i >= rx_thresh_i);
    live_o[B_RX_EMPTY] = (rx_level_i == '0);
    live_o[B_RX_FULL]  = (rx_level_i == FULL_LVL);
    live_o[B_TX_EMPTY] = (tx_level_i == '0);
    live_o[B_TX_FULL]  = (tx_level_i == FULL_LVL);
    live_o[L_TX_TRIG]  = (tx_level_i >= tx_thresh_i);
  end

endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky
  import uirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] q_n;
  logic [DW-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_en_i ? clr_i : '0;
    // a new set wins over a same-cycle clear
    q_n     = ((q_o & ~clr_eff) | set_i) & IMPL_BITS;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_n;
  end

  // R3 R4 R6: every set source is present one cycle later
  a_r6_set_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(set_i & IMPL_BITS)) == $past(set_i & IMPL_BITS)));

  // R5: written ones without a competing set are gone
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en_i |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  // R9: unimplemented bits never appear
  a_r9_impl_only: assert property (@(posedge clk) disable iff (!rst_ni)
    ((q_o & ~IMPL_BITS) == '0));

endmodule

// File: rtl/uirq_mask.sv
module uirq_mask
  import uirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          set_en_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] q_n;
  logic          upd;

  always_comb begin
    upd = set_en_i | clr_en_i;
    q_n = q_o;
    if (set_en_i) q_n = q_o | (wdata_i & IMPL_BITS);
    if (clr_en_i) q_n = q_o & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  q_o <= '0;
    else if (upd) q_o <= q_n;
  end

  // R7: set port adds written bits
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_ni)
    set_en_i |=> ((q_o & $past(wdata_i & IMPL_BITS)) == $past(wdata_i & IMPL_BITS)));

  // R7: clear port removes written bits
  a_r7_clr: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en_i |=> ((q_o & $past(wdata_i)) == '0));

  // R7: no port write, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i) |=> $stable(q_o));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int AW = 3,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] rx_thresh,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] tx_thresh,
  input  logic          ev_rx_overrun,
  input  logic          ev_framing,
  input  logic          ev_parity,
  input  logic          ev_rx_timeout,
  input  logic          ev_modem,
  input  logic          ev_tx_overrun,
  output logic          irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [DW-1:0] live_w;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] sticky_q;
  logic [DW-1:0] mask_q;
  logic          wr_mset, wr_mclr, wr_sticky;
  logic          irq_n;

  always_comb begin
    wr_mset   = bus_we && (bus_addr == AW'(A_MSET));
    wr_mclr   = bus_we && (bus_addr == AW'(A_MCLR));
    wr_sticky = bus_we && (bus_addr == AW'(A_STICKY));
  end

  uirq_live #(.FIFO_DEPTH(FIFO_DEPTH)) u_live (
    .rx_level_i  (rx_level),
    .rx_thresh_i (rx_thresh),
    .tx_level_i  (tx_level),
    .tx_thresh_i (tx_thresh),
    .live_o      (live_w)
  );

  always_comb begin
    set_vec            = live_w & LIVE_FOLD;
    set_vec[B_TX_TRIG] = live_w[L_TX_TRIG];
    set_vec[B_RX_OVR]  = ev_rx_overrun;
    set_vec[B_FRAME]   = ev_framing;
    set_vec[B_PARITY]  = ev_parity;
    set_vec[B_RX_TMO]  = ev_rx_timeout;
    set_vec[B_MODEM]   = ev_modem;
    set_vec[B_TX_OVR]  = ev_tx_overrun;
  end

  uirq_sticky u_sticky (
    .clk      (clk),
    .rst_ni   (rst_sn),
    .set_i    (set_vec),
    .clr_en_i (wr_sticky),
    .clr_i    (bus_wdata),
    .q_o      (sticky_q)
  );

  uirq_mask u_mask (
    .clk      (clk),
    .rst_ni   (rst_sn),
    .set_en_i (wr_mset),
    .clr_en_i (wr_mclr),
    .wdata_i  (bus_wdata),
    .q_o      (mask_q)
  );

  always_comb irq_n = |(mask_q & sticky_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) irq <= 1'b0;
    else         irq <= irq_n;
  end

  always_comb begin
    case (bus_addr)
      AW'(A_MASK):   bus_rdata = mask_q;
      AW'(A_STICKY): bus_rdata = sticky_q;
      AW'(A_LIVE):   bus_rdata = live_w;
      default:       bus_rdata = '0;
    endcase
  end

  // R8: irq rises only after a non-empty overlap
  a_r8_rise: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq) |-> $past((mask_q & sticky_q) != 32'h0));

  // R8: irq falls only after the overlap emptied
  a_r8_fall: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(irq) |-> $past((mask_q & sticky_q) == 32'h0));

  // R2: empty and full exclusive
  a_r2_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    !(live_w[B_RX_EMPTY] && live_w[B_RX_FULL]));

endmodule

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;

  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [31:0] IMPL = 32'h0000_17FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = 3'd0;
  logic [31:0]   bus_wdata = 32'h0;
  logic [31:0]   bus_rdata;
  logic [CW-1:0] rxl = 5'd5, rxt = 5'd8, txl = 5'd5, txt = 5'd8;
  logic [5:0]    ev = 6'h0;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_mask = 32'h0;
  logic [31:0] exp_sticky = 32'hFFFF_FFFF;
  logic        exp_irq = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(DEPTH), .AW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_level(rxl), .rx_thresh(rxt), .tx_level(txl), .tx_thresh(txt),
    .ev_rx_overrun(ev[0]), .ev_framing(ev[1]), .ev_parity(ev[2]),
    .ev_rx_timeout(ev[3]), .ev_modem(ev[4]), .ev_tx_overrun(ev[5]),
    .irq(irq)
  );

  function automatic logic [31:0] live_fn(int rl, int rt, int tl, int tt);
    logic [31:0] w = 32'h0;
    w[0]  = (rl >= rt);
    w[1]  = (rl == 0);
    w[2]  = (rl == DEPTH);
    w[3]  = (tl == 0);
    w[4]  = (tl == DEPTH);
    w[13] = (tl >= tt);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    rd(3'd2, v); chk({tag, " mask"}, v, exp_mask);
    rd(3'd3, v); chk({tag, " sticky"}, v, exp_sticky);
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, exp_irq});
  endtask

  // one clock: drive at negedge, model, check at the next negedge
  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic [5:0] e, input string tag);
    logic [31:0] lv, setv, clr;
    lv   = live_fn(int'(rxl), int'(rxt), int'(txl), int'(txt));
    setv = (lv & 32'h1F) | (32'(lv[13]) << 10) | (32'(e[0]) << 5) |
           (32'(e[1]) << 6) | (32'(e[2]) << 7) | (32'(e[3]) << 8) |
           (32'(e[4]) << 9) | (32'(e[5]) << 12);
    clr  = (we && a == 3'd3) ? d : 32'h0;
    exp_irq    = |(exp_mask & exp_sticky);
    exp_sticky = ((exp_sticky & ~clr) | setv) & IMPL;
    if (we && a == 3'd0) exp_mask = exp_mask | (d & IMPL);
    if (we && a == 3'd1) exp_mask = exp_mask & ~d;
    bus_we = we; bus_addr = a; bus_wdata = d; ev = e;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; ev = 6'h0;
    check_state(tag);
  endtask

  task automatic quiet();
    rxl = 5'd5; rxt = 5'd8; txl = 5'd5; txt = 5'd8;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    // R1: state while in reset
    repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R1 mask in reset", v, 32'h0);
    rd(3'd3, v); chk("R1 sticky in reset", v, 32'h0);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: sweep every level/threshold pair
    for (int l = 0; l <= DEPTH; l++) begin
      for (int t = 0; t <= DEPTH; t++) begin
        rxl = CW'(l); rxt = CW'(t); txl = 5'd5; txt = 5'd8;
        rd(3'd4, v); chk("R2 rx live", v, live_fn(l, t, 5, 8));
        rxl = 5'd5; rxt = 5'd8; txl = CW'(l); txt = CW'(t);
        rd(3'd4, v); chk("R2 tx live", v, live_fn(5, 8, l, t));
      end
    end

    // sync the model: quiet inputs, clear everything
    quiet();
    @(negedge clk);
    step(1'b1, 3'd3, 32'hFFFF_FFFF, 6'h0, "R5 clear all");
    chk("R5 all clear", exp_sticky, 32'h0);

    // R3: live flags fold in, TX trigger lands at bit 10
    rxl = 5'd0; step(1'b0, 3'd0, 32'h0, 6'h0, "R3 rx empty");
    rxl = 5'd16; rxt = 5'd3; step(1'b0, 3'd0, 32'h0, 6'h0, "R3 rx full+trig");
    quiet(); txl = 5'd0; step(1'b0, 3'd0, 32'h0, 6'h0, "R3 tx empty");
    txl = 5'd16; txt = 5'd16; step(1'b0, 3'd0, 32'h0, 6'h0, "R3 tx full+trig");
    quiet();
    rd(3'd3, v); chk("R3 bit10 from live 13", v & 32'h0000_2400, 32'h0000_0400);

    // R6: clear while empty flag still live keeps it set
    rxl = 5'd0;
    step(1'b1, 3'd3, 32'h0000_0002, 6'h0, "R6 live beats clear");
    quiet();
    // R5: now clear succeeds, zeros untouched
    step(1'b1, 3'd3, 32'h0000_0002, 6'h0, "R5 clear rx empty");
    step(1'b1, 3'd3, 32'hFFFF_FFFF, 6'h0, "R5 clear rest");

    // R4: each event on its own
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 3'd0, 32'h0, 6'(1 << i), "R4 event");
    end
    rd(3'd3, v); chk("R4 event bits", v, 32'h0000_13E0);
    // R5: clear half, other half stays
    step(1'b1, 3'd3, 32'h0000_1060, 6'h0, "R5 partial clear");
    rd(3'd3, v); chk("R5 partial result", v, 32'h0000_0380);
    // R6: event and clear of same bit
    step(1'b1, 3'd3, 32'h0000_0020, 6'h01, "R6 event beats clear");
    rd(3'd3, v); chk("R6 bit5 kept", v & 32'h20, 32'h20);

    // R8: latency after mask write
    step(1'b1, 3'd0, 32'h0000_0020, 6'h0, "R7 enable bit5");
    chk("R8 irq not yet", {31'h0, irq}, 32'h0);
    step(1'b0, 3'd0, 32'h0, 6'h0, "R8 idle");
    chk("R8 irq one cycle later", {31'h0, irq}, 32'h1);
    step(1'b1, 3'd3, 32'h0000_0020, 6'h0, "R8 clear source");
    step(1'b0, 3'd0, 32'h0, 6'h0, "R8 idle");
    chk("R8 irq dropped", {31'h0, irq}, 32'h0);

    // R7/R8: walk every implemented bit through mask and status
    step(1'b1, 3'd3, 32'hFFFF_FFFF, 6'h0, "R5 clear all");
    for (int b = 0; b < 13; b++) begin
      if (b != 11) begin
        step(1'b1, 3'd0, 32'(1) << b, 6'h0, "R7 walk enable");
        step(1'b0, 3'd0, 32'h0, 6'h1F, "R8 events pending");
        step(1'b1, 3'd1, 32'(1) << b, 6'h0, "R7 walk disable");
        step(1'b0, 3'd0, 32'h0, 6'h0, "R8 idle");
      end
    end
    // R7: write to readback address ignored
    step(1'b1, 3'd0, 32'h0000_0300, 6'h0, "R7 enable two");
    step(1'b1, 3'd2, 32'hFFFF_FFFF, 6'h0, "R7 mask write ignored");
    step(1'b1, 3'd2, 32'h0, 6'h0, "R7 mask write zero ignored");
    // R9: full-width enable keeps only implemented bits
    step(1'b1, 3'd0, 32'hFFFF_FFFF, 6'h0, "R9 enable all");
    rd(3'd2, v); chk("R9 mask width", v, 32'h0000_17FF);
    step(1'b1, 3'd4, 32'hFFFF_FFFF, 6'h0, "R9 live write ignored");
    step(1'b1, 3'd6, 32'hFFFF_FFFF, 6'h0, "R9 unmapped write ignored");
    rd(3'd6, v); chk("R9 unmapped read", v, 32'h0);
    rd(3'd0, v); chk("R9 set port read", v, 32'h0);
    step(1'b1, 3'd1, 32'hFFFF_FFFF, 6'h0, "R7 disable all");
    step(1'b0, 3'd0, 32'h0, 6'h0, "R8 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule